// File: doc/BRIEF.md
# Receive Frame Check and Byte Bit-Order Stage

This stage sits on the receive path between the unit that finds packet boundaries and the packet buffer. It takes one tagged byte per accepted cycle (start, end and abort marks on the byte). It runs a 16-bit frame check sequence over every packet and cuts the two check bytes off the tail of the packet. The end mark moves onto the last byte that is kept, and a packet whose check fails gets an error mark on that byte. When checking is switched off, the packet goes through untouched and unchecked. A separate switch picks the bit order each byte has on the output.

Two bytes are held back inside the stage, so stripping needs no look-ahead from upstream. A byte becomes visible one cycle after the input byte that pushes it out. Packets of one or two bytes have no room for a check field. An aborted packet keeps its abort mark and is never also flagged as a check failure.

Top module: `fcs_strip_reorder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `out_valid`, `out_sop`, `out_eop`, `out_err`, `out_abort` and `out_data` all zero.
- R2: The check uses the reflected form of x^16+x^12+x^5+1 (shift-right constant 0x8408) with the register preset to 0xFFFF. Bits enter in arrival order, and `in_data[7]` is the first bit received in a byte. A packet passes when the register equals 0xF0B8 after its last byte. The sender places the complemented check value low byte first, with each check byte's bit 0 sent first. A passing packet has `out_err` low on its end byte.
- R3: With checking on, a packet of three or more bytes that fails the check has `out_err` high on its end output byte and low on every other byte.
- R4: With checking on, a packet of N ≥ 3 bytes comes out as its first N-2 bytes in order. `out_sop` is on the first of these and `out_eop` on the last.
- R5: `fcs_en` is sampled with the start byte and holds for that whole packet. When it is low, all N bytes come out with start and end marks where they entered, and `out_err` is never set.
- R6: With `reorder_en` high, `out_data` equals the input byte. With it low, `out_data[i]` equals `in_data[7-i]`.
- R7: With checking on, a packet of one or two bytes yields exactly one output byte. That byte is the packet's first byte, with `out_sop`, `out_eop` and `out_err` all high.
- R8: `in_abort` is valid together with `in_eop`. The packet's end output byte then carries `out_abort` high and `out_err` low, in either checking mode.
- R9: An output byte appears only in the cycle after a cycle with `in_valid` high. Every input end byte is matched by an output end byte in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fcs_en | input | 1 | Check-and-strip enable, taken at packet start |
| reorder_en | input | 1 | Output bit order select |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte, bit 7 received first |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_abort | input | 1 | Packet ended by abort (with in_eop) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte in the selected bit order |
| out_sop | output | 1 | First output byte of a packet |
| out_eop | output | 1 | Last output byte of a packet |
| out_err | output | 1 | Check failure on the end byte |
| out_abort | output | 1 | Abort carried onto the end byte |

## Verification
The bench targets three-byte packets, where the only kept byte must carry both marks. A design that moved the end mark off by one would lose that byte or emit a check byte. One- and two-byte packets are sent with checking on. A stage that waited for a full hold would emit nothing, and a bench counting end bytes catches that. Aborted packets, both short and long, and check failures from a single flipped bit show any design that sets the error and abort marks together, or that reads the check register before the last byte is folded in. Mode and bit-order switches between packets, with random idle gaps, catch designs that sample the enable mid-packet or reverse the bits the wrong way.

// File: rtl/fcsr_pkg.sv
// Package: shared tag bundle and default constants for the receive
// frame-check stage. Assumes a byte-wide stream and a 16-bit check.
package fcsr_pkg;

    // Marks travelling with each byte
    typedef struct packed {
        logic sop;
        logic eop;
        logic err;
        logic abort;
    } fcsr_tag_t;

    localparam logic [15:0] FCSR_POLY_REFL = 16'h8408;
    localparam logic [15:0] FCSR_PRESET    = 16'hFFFF;
    localparam logic [15:0] FCSR_GOOD_RES  = 16'hF0B8;

endpackage

// File: rtl/fcsr_crc_step.sv
// Module: folds one byte into a reflected CRC register, bits in arrival
// order (DATA_W-1 first). Purely combinational. Assumes the reflected
// polynomial constant (shift-right form).
module fcsr_crc_step #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // Serial shift over every bit of the byte, first-received bit first
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[0] ^ data_in[i];
            c  = c >> 1;
            if (fb) begin
                c = c ^ POLY;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/fcsr_bit_order.sv
// Module: selects the output bit order of a byte. With sel_keep high the
// byte passes as is; low, the bits are mirrored (bit i <- bit W-1-i).
module fcsr_bit_order #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              sel_keep,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // One mux per output bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = sel_keep ? din[i] : din[DATA_W-1-i];
    end

endmodule

// File: rtl/fcsr_hold_ctrl.sv
// Module: holding line and packet control. Keeps the newest HOLD bytes of
// a checked packet back so the trailing check bytes can be dropped when
// the end byte arrives; the emitted byte then takes the end mark and the
// check verdict. Assumes well-formed packets; a start byte discards
// anything still held. The CRC step is external (crc_base/crc_new).
module fcsr_hold_ctrl
    import fcsr_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] PRESET  = 16'hFFFF,
    parameter logic [CRC_W-1:0] GOOD_RES = 16'hF0B8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcs_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_abort,
    input  logic [CRC_W-1:0]  crc_new,
    output logic [CRC_W-1:0]  crc_base,
    output logic              emit_valid,
    output logic [DATA_W-1:0] emit_data,
    output fcsr_tag_t         emit_tag
);

    localparam int unsigned HOLD  = CRC_W / DATA_W;
    localparam int unsigned CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD);

    logic [DATA_W-1:0] hd_q [HOLD];
    logic [DATA_W-1:0] hd_d [HOLD];
    logic [HOLD-1:0]   hs_q, hs_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, eff_cnt;
    logic [CRC_W-1:0]  crc_q, crc_d;
    logic              mode_q, mode_d, mode_use;

    // Packet-level view of the current byte
    always_comb begin
        mode_use = in_sop ? fcs_en : mode_q;
        eff_cnt  = in_sop ? '0 : cnt_q;
        crc_base = in_sop ? PRESET : crc_q;
    end

    // Next-state and emit decision for one accepted byte
    always_comb begin
        hd_d       = hd_q;
        hs_d       = hs_q;
        cnt_d      = cnt_q;
        crc_d      = crc_q;
        mode_d     = mode_q;
        emit_valid = 1'b0;
        emit_data  = '0;
        emit_tag   = '0;
        if (in_valid) begin
            mode_d = mode_use;
            crc_d  = crc_new;
            if (!mode_use) begin
                emit_valid     = 1'b1;
                emit_data      = in_data;
                emit_tag.sop   = in_sop;
                emit_tag.eop   = in_eop;
                emit_tag.abort = in_eop & in_abort;
                cnt_d          = '0;
            end else if (in_eop) begin
                cnt_d          = '0;
                emit_valid     = 1'b1;
                emit_tag.eop   = 1'b1;
                emit_tag.abort = in_abort;
                if (eff_cnt == CNT_FULL) begin
                    emit_data    = hd_q[0];
                    emit_tag.sop = hs_q[0];
                    emit_tag.err = !in_abort && (crc_new != GOOD_RES);
                end else begin
                    emit_data    = (eff_cnt == '0) ? in_data : hd_q[0];
                    emit_tag.sop = 1'b1;
                    emit_tag.err = !in_abort;
                end
            end else if (eff_cnt == CNT_FULL) begin
                emit_valid   = 1'b1;
                emit_data    = hd_q[0];
                emit_tag.sop = hs_q[0];
                for (int k = 0; k < int'(HOLD) - 1; k++) begin
                    hd_d[k] = hd_q[k+1];
                    hs_d[k] = hs_q[k+1];
                end
                hd_d[HOLD-1] = in_data;
                hs_d[HOLD-1] = in_sop;
            end else begin
                for (int k = 0; k < int'(HOLD); k++) begin
                    if (CNT_W'(k) == eff_cnt) begin
                        hd_d[k] = in_data;
                        hs_d[k] = in_sop;
                    end
                end
                cnt_d = eff_cnt + CNT_W'(1);
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(HOLD); k++) begin
                hd_q[k] <= '0;
            end
            hs_q   <= '0;
            cnt_q  <= '0;
            crc_q  <= PRESET;
            mode_q <= 1'b0;
        end else begin
            hd_q   <= hd_d;
            hs_q   <= hs_d;
            cnt_q  <= cnt_d;
            crc_q  <= crc_d;
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/fcs_strip_reorder.sv
// Top: receive frame-check, check-byte strip and bit-order stage. One byte
// per cycle in, registered byte out. Assumes in_abort only with in_eop and
// control inputs steady within a packet.
module fcs_strip_reorder
    import fcsr_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY     = FCSR_POLY_REFL,
    parameter logic [CRC_W-1:0] PRESET   = FCSR_PRESET,
    parameter logic [CRC_W-1:0] GOOD_RES = FCSR_GOOD_RES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcs_en,
    input  logic              reorder_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_abort,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              out_abort
);

    logic [CRC_W-1:0]  crc_base, crc_new;
    logic              emit_valid;
    logic [DATA_W-1:0] emit_data, emit_ord;
    fcsr_tag_t         emit_tag;

    fcsr_crc_step #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY)
    ) u_crc (
        .crc_in  (crc_base),
        .data_in (in_data),
        .crc_out (crc_new)
    );

    fcsr_hold_ctrl #(
        .DATA_W   (DATA_W),
        .CRC_W    (CRC_W),
        .PRESET   (PRESET),
        .GOOD_RES (GOOD_RES)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .fcs_en     (fcs_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_abort   (in_abort),
        .crc_new    (crc_new),
        .crc_base   (crc_base),
        .emit_valid (emit_valid),
        .emit_data  (emit_data),
        .emit_tag   (emit_tag)
    );

    fcsr_bit_order #(
        .DATA_W (DATA_W)
    ) u_order (
        .sel_keep (reorder_en),
        .din      (emit_data),
        .dout     (emit_ord)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            out_abort <= 1'b0;
        end else begin
            out_valid <= emit_valid;
            out_data  <= emit_ord;
            out_sop   <= emit_tag.sop;
            out_eop   <= emit_tag.eop;
            out_err   <= emit_tag.err;
            out_abort <= emit_tag.abort;
        end
    end

endmodule

// File: rtl/fcs_strip_reorder_chk.sv
// Checker: port-level properties of the frame-check stage, bound to the top.
module fcs_strip_reorder_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fcs_en,
    input logic              reorder_en,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_sop,
    input logic              in_eop,
    input logic              in_abort,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_err,
    input logic              out_abort
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_sop && !out_eop && !out_err && !out_abort); // R1

    AST_ERR_ON_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid && out_eop); // R3

    AST_BYPASS_START: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sop && !fcs_en |=> out_valid && out_sop && !out_err); // R5

    AST_BYPASS_KEEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sop && !fcs_en && reorder_en |=> out_data == $past(in_data)); // R6

    AST_ABORT_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eop && in_abort |=> out_abort && !out_err); // R8

    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_END_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eop |=> out_valid && out_eop); // R9

endmodule

bind fcs_strip_reorder fcs_strip_reorder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fcs_en     (fcs_en),
    .reorder_en (reorder_en),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .in_abort   (in_abort),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_err    (out_err),
    .out_abort  (out_abort)
);

// File: tb/fcs_strip_reorder_tb.sv
// Bench: directed corner packets then seeded random packets; an expected
// byte queue is built from the requirements and compared at the output.
module fcs_strip_reorder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcs_en = 1'b0, reorder_en = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid, out_sop, out_eop, out_err, out_abort;
    logic [7:0] out_data;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;
    logic prev_in = 1'b0;

    logic [11:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  pkt [0:39];

    always #2 clk = ~clk;

    fcs_strip_reorder u_dut (
        .clk(clk), .rst_n(rst_n), .fcs_en(fcs_en), .reorder_en(reorder_en),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_abort(in_abort), .out_valid(out_valid),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_err(out_err), .out_abort(out_abort)
    );

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x = c;
        for (int i = 7; i >= 0; i--) begin
            if (x[0] ^ d[i]) x = (x >> 1) ^ 16'h8408;
            else             x = x >> 1;
        end
        return x;
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Output monitor: compares every output byte with the expected queue
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            checks++;
            if (!prev_in) begin
                bad++;
                $display("FAIL R9 output without input act=1 exp=0");
            end
            if (exp_q.size() == 0) begin
                check("R9 unexpected byte", {out_data, out_sop, out_eop, out_err, out_abort}, 12'hxxx);
            end else begin
                check(tag_q.pop_front(), {out_data, out_sop, out_eop, out_err, out_abort}, exp_q.pop_front());
            end
        end
        prev_in = in_valid;
    end

    task automatic drive_byte(input logic [7:0] d, input logic s, input logic e, input logic a);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_abort = a;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_abort = 1'b0;
    endtask

    // Builds, predicts and sends one packet of n bytes
    task automatic send_pkt(input int n, input bit fcs, input bit keep, input bit abrt,
                            input bit corrupt, input bit gaps);
        logic [15:0] c;
        logic [15:0] f;
        bit          fail;
        string       tg;
        int          nout;
        for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
        if (n >= 3) begin
            c = 16'hFFFF;
            for (int i = 0; i < n - 2; i++) c = fold(c, pkt[i]);
            f = ~c;
            pkt[n-2] = rev8(f[7:0]);
            pkt[n-1] = rev8(f[15:8]);
            if (corrupt) pkt[$urandom % n] ^= 8'(1 << ($urandom % 8));
        end
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = fold(c, pkt[i]);
        fail = (c != 16'hF0B8);
        if (!fcs)          begin nout = n;     tg = abrt ? "R5 R8 R6" : "R5 R6"; end
        else if (n < 3)    begin nout = 1;     tg = abrt ? "R7 R8 R6" : "R7 R6"; end
        else if (abrt)     begin nout = n - 2; tg = "R4 R8 R6"; end
        else if (fail)     begin nout = n - 2; tg = "R3 R4 R6"; end
        else               begin nout = n - 2; tg = "R2 R4 R6"; end
        for (int i = 0; i < nout; i++) begin
            logic l = (i == nout - 1);
            logic er = fcs && l && !abrt && ((n < 3) || fail);
            exp_q.push_back({keep ? pkt[i] : rev8(pkt[i]), i == 0, l, er, l && abrt});
            tag_q.push_back(tg);
        end
        fcs_en = fcs; reorder_en = keep;
        for (int i = 0; i < n; i++) begin
            if (gaps) repeat ($urandom % 3) @(posedge clk);
            #0 drive_byte(pkt[i], i == 0, i == n - 1, abrt && i == n - 1);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {out_data, out_sop, out_eop, out_err, out_abort, out_valid}, 13'h0 >> 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        mon_on = 1;
        // directed corners
        send_pkt(3, 1, 1, 0, 0, 0);   // R4 single kept byte
        send_pkt(1, 1, 0, 0, 0, 0);   // R7 one byte
        send_pkt(2, 1, 1, 0, 0, 0);   // R7 two bytes
        send_pkt(8, 1, 0, 0, 1, 0);   // R3 bad check
        send_pkt(8, 1, 1, 1, 0, 0);   // R8 long abort
        send_pkt(2, 1, 0, 1, 0, 0);   // R8 short abort
        send_pkt(6, 0, 1, 0, 0, 0);   // R5 bypass
        send_pkt(5, 0, 0, 1, 0, 0);   // R5 bypass abort
        send_pkt(12, 1, 0, 0, 0, 1);  // R2 good with gaps
        // random mix
        for (int p = 0; p < 250; p++) begin
            int  n    = 1 + int'($urandom % 20);
            bit  fcs  = ($urandom % 4) != 0;
            bit  keep = $urandom % 2;
            bit  ab   = ($urandom % 8) == 0;
            bit  cor  = ($urandom % 4) == 0;
            send_pkt(n, fcs, keep, ab, cor, $urandom % 2);
            repeat ($urandom % 3) @(posedge clk);
        end
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R9 missing bytes act=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule